// File: doc/BRIEF.md
# Message Buffer Completion Flag and Interrupt Unit

This block holds one sticky completion flag per message buffer of a CAN-style controller, together with a mask register of the same width, and drives a single CPU interrupt line. The buffer engine reports a completed transmit or receive as a one-cycle pulse on the matching bit of `evt_done`. The CPU reads the flags and clears them by writing ones. It loads the mask register with a separate write strobe.

Two mode inputs change what the lowest flag bits mean. With `fifo_en` high, bit 7 records a receive FIFO overflow and no longer records buffer 7. When `fifo_en` and `dma_en` are both high (the DMA FIFO mode), the low eight bits are taken over by the FIFO. Bit 5 follows the FIFO "data available" level and drives `dma_req`. A CPU write of one to bit 0 sends a one-cycle flush pulse to the FIFO. All the other low bits stay at zero, and the low eight bits never reach the CPU interrupt.

All event, write and mode inputs are single-cycle or level control pins. No data stream passes through the block, so there is no valid/ready back-pressure. Every input is accepted on the clock edge where it is present.

Top module: `buf_irq_flags`

## Requirements
- R1: While `rst_n` is low, and just after reset, `flags_rd`, `mask_rd`, `irq`, `dma_req` and `fifo_flush` are all 0.
- R2: A pulse on `evt_done[i]` sets `flags_rd[i]` from the next clock edge, and the bit stays set until it is cleared. This applies when bit i is an ordinary buffer flag: it is not bit 7 with `fifo_en` high, and it is not one of bits 7..0 in DMA FIFO mode.
- R3: When `wr_en` is high, every bit where `wr_data` is 1 is cleared at the next edge. Bits where `wr_data` is 0 keep their value.
- R4: If a set event and a write-one-to-clear reach the same bit in the same cycle, the bit is 1 after the edge.
- R5: With `fifo_en` high, bit 7 is set by `fifo_ovf` and `evt_done[7]` has no effect on it. With `fifo_en` low, `fifo_ovf` has no effect.
- R6: In DMA FIFO mode (`fifo_en` and `dma_en` both high), bits 7, 6 and 4..0 of `flags_rd` read 0 from the next edge onward and are not set by any event.
- R7: In DMA FIFO mode, `flags_rd[5]` equals the value `fifo_avail` had one cycle earlier, and CPU writes do not clear it. `dma_req` is high exactly when this bit is 1 and the mode is active.
- R8: In DMA FIFO mode, a write with `wr_data[0]`=1 makes `fifo_flush` high for exactly the next cycle. Outside this mode the same write gives no pulse.
- R9: `irq` is high when some bit has both its flag and its mask bit set. It changes in the same cycle as the flag or mask. In DMA FIFO mode, bits 7..0 are left out of this OR.
- R10: `mask_wr_en` loads `mask_wr_data` into the mask register, and the new value is visible on `mask_rd` after the next edge.
- R11: An `evt_done[i]` with i greater than `max_idx` does not set flag i. A flag that is already set keeps its value until the CPU clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Receive FIFO mode enable |
| dma_en | input | 1 | DMA mode enable |
| max_idx | input | 5 | Highest buffer index whose events are accepted |
| evt_done | input | 32 | One-cycle completion events, one per buffer |
| fifo_ovf | input | 1 | Receive FIFO overflow event |
| fifo_avail | input | 1 | Receive FIFO holds data (level) |
| wr_en | input | 1 | Flag write strobe (write-one-to-clear) |
| wr_data | input | 32 | Flag write data |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 32 | Mask write data |
| flags_rd | output | 32 | Current flag bits |
| mask_rd | output | 32 | Current mask bits |
| irq | output | 1 | CPU interrupt request |
| dma_req | output | 1 | DMA request for the receive FIFO |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |

## Verification
Flag, mask and flush results appear one clock edge after the input that causes them, because each passes through one register. `irq` and `dma_req` follow the current flag, mask and mode values in the same cycle. The bench drives inputs shortly after the rising edge and compares every output with a behavioural model at the falling edge. At that point the model has taken the same edge and the combinational outputs have settled on the current mode inputs. Collisions, mode entry and exit, and writes to the FIFO bits get their own stretches of stimulus, and a long randomized stretch follows them.

// File: rtl/buf_irq_pkg.sv
`timescale 1ns/1ps
package buf_irq_pkg;
  // Role a flag bit plays in the current mode
  typedef enum logic [1:0] {
    ROLE_BUF   = 2'd0,  // ordinary buffer completion flag
    ROLE_OVF   = 2'd1,  // receive FIFO overflow flag
    ROLE_AVAIL = 2'd2,  // FIFO data-available level (DMA FIFO mode)
    ROLE_OFF   = 2'd3   // unused, held at zero
  } bit_role_e;
endpackage

// File: rtl/buf_irq_mode_dec.sv
`timescale 1ns/1ps
module buf_irq_mode_dec
  import buf_irq_pkg::*;
#(
  parameter int NUM_BUF   = 32,
  parameter int FIFO_SPAN = 8,
  parameter int OVF_BIT   = 7,
  parameter int AVAIL_BIT = 5
) (
  input  logic      fifo_en,
  input  logic      dma_en,
  output bit_role_e role_o [NUM_BUF],
  output logic [NUM_BUF-1:0] irq_keep_o,
  output logic      fifo_dma_o
);
  assign fifo_dma_o = fifo_en & dma_en;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_bit
    if (i < FIFO_SPAN) begin : g_low
      always_comb begin
        if (fifo_dma_o) begin
          role_o[i]     = (i == AVAIL_BIT) ? ROLE_AVAIL : ROLE_OFF;
          irq_keep_o[i] = 1'b0;
        end else begin
          role_o[i]     = (fifo_en && i == OVF_BIT) ? ROLE_OVF : ROLE_BUF;
          irq_keep_o[i] = 1'b1;
        end
      end
    end else begin : g_high
      assign role_o[i]     = ROLE_BUF;
      assign irq_keep_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/buf_irq_flag_bank.sv
`timescale 1ns/1ps
module buf_irq_flag_bank
  import buf_irq_pkg::*;
#(
  parameter int NUM_BUF = 32,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bit_role_e          role_i [NUM_BUF],
  input  logic [IDX_W-1:0]   max_idx,
  input  logic [NUM_BUF-1:0] evt_done,
  input  logic               fifo_ovf,
  input  logic               fifo_avail,
  input  logic               clr_en,
  input  logic [NUM_BUF-1:0] clr_data,
  output logic [NUM_BUF-1:0] flags_o
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic set_ev;
    logic clr_hit;

    assign clr_hit = clr_en & clr_data[i];

    always_comb begin
      case (role_i[i])
        ROLE_BUF: set_ev = evt_done[i] & (IDX <= max_idx);
        ROLE_OVF: set_ev = fifo_ovf;
        default:  set_ev = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_o[i] <= 1'b0;
      end else begin
        case (role_i[i])
          ROLE_OFF:   flags_o[i] <= 1'b0;
          ROLE_AVAIL: flags_o[i] <= fifo_avail;
          default:    flags_o[i] <= set_ev | (flags_o[i] & ~clr_hit);
        endcase
      end
    end
  end
endmodule

// File: rtl/buf_irq_mask_reg.sv
`timescale 1ns/1ps
module buf_irq_mask_reg #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wr_data,
  output logic [NUM_BUF-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_o <= '0;
    else if (wr_en) mask_o <= wr_data;
  end
endmodule

// File: rtl/buf_irq_out.sv
`timescale 1ns/1ps
module buf_irq_out #(
  parameter int NUM_BUF   = 32,
  parameter int AVAIL_BIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] flags_i,
  input  logic [NUM_BUF-1:0] mask_i,
  input  logic [NUM_BUF-1:0] keep_i,
  input  logic               fifo_dma_i,
  input  logic               flush_wr_i,
  output logic               irq_o,
  output logic               dma_req_o,
  output logic               flush_o
);
  assign irq_o     = |(flags_i & mask_i & keep_i);
  assign dma_req_o = fifo_dma_i & flags_i[AVAIL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_o <= 1'b0;
    else        flush_o <= fifo_dma_i & flush_wr_i;
  end
endmodule

// File: rtl/buf_irq_flags.sv
`timescale 1ns/1ps
module buf_irq_flags
  import buf_irq_pkg::*;
#(
  parameter int NUM_BUF   = 32,
  parameter int FIFO_SPAN = 8,
  parameter int OVF_BIT   = 7,
  parameter int AVAIL_BIT = 5,
  parameter int FLUSH_BIT = 0,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               dma_en,
  input  logic [IDX_W-1:0]   max_idx,
  input  logic [NUM_BUF-1:0] evt_done,
  input  logic               fifo_ovf,
  input  logic               fifo_avail,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wr_data,
  input  logic               mask_wr_en,
  input  logic [NUM_BUF-1:0] mask_wr_data,
  output logic [NUM_BUF-1:0] flags_rd,
  output logic [NUM_BUF-1:0] mask_rd,
  output logic               irq,
  output logic               dma_req,
  output logic               fifo_flush
);
  bit_role_e          role [NUM_BUF];
  logic [NUM_BUF-1:0] irq_keep;
  logic               fifo_dma;

  buf_irq_mode_dec #(
    .NUM_BUF(NUM_BUF), .FIFO_SPAN(FIFO_SPAN),
    .OVF_BIT(OVF_BIT), .AVAIL_BIT(AVAIL_BIT)
  ) u_dec (
    .fifo_en(fifo_en), .dma_en(dma_en),
    .role_o(role), .irq_keep_o(irq_keep), .fifo_dma_o(fifo_dma)
  );

  buf_irq_flag_bank #(.NUM_BUF(NUM_BUF)) u_bank (
    .clk(clk), .rst_n(rst_n), .role_i(role), .max_idx(max_idx),
    .evt_done(evt_done), .fifo_ovf(fifo_ovf), .fifo_avail(fifo_avail),
    .clr_en(wr_en), .clr_data(wr_data), .flags_o(flags_rd)
  );

  buf_irq_mask_reg #(.NUM_BUF(NUM_BUF)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en),
    .wr_data(mask_wr_data), .mask_o(mask_rd)
  );

  buf_irq_out #(.NUM_BUF(NUM_BUF), .AVAIL_BIT(AVAIL_BIT)) u_out (
    .clk(clk), .rst_n(rst_n), .flags_i(flags_rd), .mask_i(mask_rd),
    .keep_i(irq_keep), .fifo_dma_i(fifo_dma),
    .flush_wr_i(wr_en & wr_data[FLUSH_BIT]),
    .irq_o(irq), .dma_req_o(dma_req), .flush_o(fifo_flush)
  );
endmodule

// File: rtl/buf_irq_flags_chk.sv
`timescale 1ns/1ps
module buf_irq_flags_chk #(
  parameter int NUM_BUF   = 32,
  parameter int FIFO_SPAN = 8,
  parameter int AVAIL_BIT = 5,
  parameter int FLUSH_BIT = 0,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifo_en,
  input logic               dma_en,
  input logic [IDX_W-1:0]   max_idx,
  input logic [NUM_BUF-1:0] evt_done,
  input logic               fifo_avail,
  input logic               wr_en,
  input logic [NUM_BUF-1:0] wr_data,
  input logic [NUM_BUF-1:0] flags_rd,
  input logic [NUM_BUF-1:0] mask_rd,
  input logic               irq,
  input logic               dma_req,
  input logic               fifo_flush
);
  localparam logic [NUM_BUF-1:0] LOW_ALL    = NUM_BUF'((64'd1 << FIFO_SPAN) - 64'd1);
  localparam logic [NUM_BUF-1:0] LOW_UNUSED = LOW_ALL & ~(NUM_BUF'(1) << AVAIL_BIT);
  localparam int TOP = NUM_BUF - 1;

  logic dmode;
  assign dmode = fifo_en & dma_en;

  // R6: unused low bits read zero after a cycle in DMA FIFO mode
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dmode |=> ((flags_rd & LOW_UNUSED) == '0));

  // R7: bit 5 tracks the FIFO level one cycle later
  a_r7_avail_follow: assert property (@(posedge clk) disable iff (!rst_n)
    dmode |=> (flags_rd[AVAIL_BIT] == $past(fifo_avail)));

  // R7: empty FIFO drops the DMA request on the next cycle
  a_r7_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode && !fifo_avail) |=> !dma_req);

  // R8: flush pulse only after a bit-0 write in DMA FIFO mode
  a_r8_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode && wr_en && wr_data[FLUSH_BIT]) |=> fifo_flush);
  a_r8_flush_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmode && wr_en && wr_data[FLUSH_BIT]) |=> !fifo_flush);

  // R9: low region never raises the CPU interrupt in DMA FIFO mode
  a_r9_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode && ((flags_rd & mask_rd & ~LOW_ALL) == '0)) |-> !irq);

  // R3: clear of the top buffer without a set event
  a_r3_w1c_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[TOP] && !evt_done[TOP]) |=> !flags_rd[TOP]);

  // R4: set wins over clear on the top buffer
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done[TOP] && max_idx == IDX_W'(TOP)) |=> flags_rd[TOP]);

  // R11: top buffer above the limit never newly sets
  a_r11_above_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_rd[TOP] && max_idx != IDX_W'(TOP)) |=> !flags_rd[TOP]);
endmodule

bind buf_irq_flags buf_irq_flags_chk #(
  .NUM_BUF(NUM_BUF), .FIFO_SPAN(FIFO_SPAN),
  .AVAIL_BIT(AVAIL_BIT), .FLUSH_BIT(FLUSH_BIT)
) u_chk (.*);

// File: tb/buf_irq_flags_tb_top.sv
`timescale 1ns/1ps
module buf_irq_flags_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_en = 1'b0, dma_en = 1'b0;
  logic [4:0]    max_idx = 5'd31;
  logic [N-1:0]  evt_done = '0;
  logic          fifo_ovf = 1'b0, fifo_avail = 1'b0;
  logic          wr_en = 1'b0;
  logic [N-1:0]  wr_data = '0;
  logic          mask_wr_en = 1'b0;
  logic [N-1:0]  mask_wr_data = '0;
  logic [N-1:0]  flags_rd, mask_rd;
  logic          irq, dma_req, fifo_flush;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk; // 50 MHz

  buf_irq_flags dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
    .max_idx(max_idx), .evt_done(evt_done), .fifo_ovf(fifo_ovf),
    .fifo_avail(fifo_avail), .wr_en(wr_en), .wr_data(wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .flags_rd(flags_rd), .mask_rd(mask_rd), .irq(irq),
    .dma_req(dma_req), .fifo_flush(fifo_flush)
  );

  // Behavioural reference model
  bit [N-1:0] m_flags = '0;
  bit [N-1:0] m_mask = '0;
  bit         m_flush = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0; m_mask = '0; m_flush = 0;
    end else begin
      bit [N-1:0] nf;
      bit dm;
      dm = fifo_en && dma_en;
      for (int i = 0; i < N; i++) begin
        if (dm && i < 8 && i != 5)      nf[i] = 0;
        else if (dm && i == 5)          nf[i] = fifo_avail;
        else begin
          bit s;
          if (fifo_en && i == 7) s = fifo_ovf;
          else                   s = evt_done[i] && (i <= int'(max_idx));
          nf[i] = s || (m_flags[i] && !(wr_en && wr_data[i]));
        end
      end
      m_flags = nf;
      if (mask_wr_en) m_mask = mask_wr_data;
      m_flush = wr_en && wr_data[0] && dm;
    end
  end

  task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_irq;
      bit dm;
      dm = fifo_en && dma_en;
      e_irq = 0;
      for (int i = 0; i < N; i++)
        if (m_flags[i] && m_mask[i] && !(dm && i < 8)) e_irq = 1;
      check(cur_req, "flags", flags_rd, m_flags);
      check("R10", "mask", mask_rd, m_mask);
      check("R9", "irq", N'(irq), N'(e_irq));
      check("R7", "dma_req", N'(dma_req), N'(m_flags[5] && dm));
      check("R8", "fifo_flush", N'(fifo_flush), N'(m_flush));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    evt_done = '0; fifo_ovf = 0; wr_en = 0; wr_data = '0; mask_wr_en = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", "flags in reset", flags_rd, '0);
    check("R1", "outputs in reset", N'({irq, dma_req, fifo_flush}), '0);
    rst_n = 1;
    tick();

    // R2: events on several buffers
    cur_req = "R2";
    evt_done = 32'h8000_0101; tick();
    evt_done = 32'h0042_0000; tick();
    tick();
    check("R2", "sticky flags", flags_rd, 32'h8042_0101);

    // R10 / R9: mask and interrupt
    mask_wr_en = 1; mask_wr_data = 32'h0040_0000; tick();
    tick();
    mask_wr_en = 1; mask_wr_data = 32'h0000_0000; tick();

    // R3: write-one-to-clear, zeros ignored
    cur_req = "R3";
    wr_en = 1; wr_data = 32'h0002_0001; tick();
    wr_en = 1; wr_data = 32'h0000_0000; tick();
    wr_en = 1; wr_data = 32'hFFFF_FFFF; tick();
    check("R3", "all cleared", flags_rd, '0);

    // R4: set and clear in one cycle
    cur_req = "R4";
    evt_done = 32'h8000_0010; wr_en = 1; wr_data = 32'h8000_0010; tick();
    check("R4", "set wins", flags_rd, 32'h8000_0010);
    wr_en = 1; wr_data = '1; tick();

    // R5: bit 7 as overflow flag
    cur_req = "R5";
    fifo_en = 1; evt_done = 32'h80; tick();
    check("R5", "bit7 ignores buffer event", flags_rd, '0);
    fifo_ovf = 1; tick();
    check("R5", "bit7 overflow", flags_rd, 32'h80);
    fifo_en = 0; wr_en = 1; wr_data = '1; tick();
    fifo_ovf = 1; tick();
    check("R5", "overflow ignored w/o fifo", flags_rd, '0);

    // R6 / R7 / R8: DMA FIFO mode
    cur_req = "R6";
    evt_done = 32'h0000_00FF; tick();
    mask_wr_en = 1; mask_wr_data = 32'h0000_00FF; fifo_en = 1; dma_en = 1; tick();
    check("R6", "low bits zero", flags_rd & 32'hDF, '0);
    evt_done = 32'hFF; fifo_ovf = 1; tick();
    cur_req = "R7";
    fifo_avail = 1; tick();
    tick();
    check("R7", "dma_req high", N'(dma_req), N'(1));
    wr_en = 1; wr_data = 32'h20; tick();
    check("R7", "bit5 not cleared", N'(flags_rd[5]), N'(1));
    cur_req = "R8";
    wr_en = 1; wr_data = 32'h01; tick();
    #10;
    check("R8", "flush pulse", N'(fifo_flush), N'(1));
    tick();
    fifo_avail = 0; tick();
    tick();
    dma_en = 0; wr_en = 1; wr_data = 32'h01; tick();
    fifo_en = 0; tick();
    tick();

    // R11: maximum buffer index
    cur_req = "R11";
    evt_done = 32'h0000_1000; tick();
    max_idx = 5'd7; evt_done = 32'hFFFF_FF00; tick();
    check("R11", "above max ignored, old kept", flags_rd, 32'h0000_1000);
    wr_en = 1; wr_data = 32'h0000_1000; tick();
    max_idx = 5'd31;

    // Randomized mix
    cur_req = "R2";
    for (int k = 0; k < 2000; k++) begin
      evt_done = $urandom & $urandom;
      fifo_ovf = $urandom_range(0, 3) == 0;
      fifo_avail = $urandom_range(0, 1);
      wr_en = $urandom_range(0, 2) == 0;
      wr_data = $urandom;
      mask_wr_en = $urandom_range(0, 7) == 0;
      mask_wr_data = $urandom;
      if ($urandom_range(0, 15) == 0) begin
        fifo_en = $urandom_range(0, 1);
        dma_en = $urandom_range(0, 1);
      end
      if ($urandom_range(0, 31) == 0) max_idx = 5'($urandom);
      tick();
    end

    @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule